// File: doc/BRIEF.md
# Zero-Address Stack Calculator

This block is a small evaluation engine for a zero-operand instruction format. Commands arrive one at a time over a valid/ready handshake. Each command names an operation and, for a push, carries a data word. The block holds its operands in a 16-entry last-in, first-out store. A push places a word on top. A pop takes the top word away and returns it on an output port. The four arithmetic commands each take the two upper entries and leave one result in their place.

All arithmetic is 16-bit two's complement. Addition, subtraction and multiplication finish in the cycle that accepts the command. Division uses a shift-and-subtract unit that works one quotient bit per cycle, and the block refuses new commands until it has finished. The top-of-stack value and the fill level are always visible on the ports. Single-cycle flags report a push onto a full store, a command that needs more entries than the store holds, and a division by zero.

Top module: `stack_calc`

## Requirements
- R1: An accepted push (cmd_op code 0) with fewer than 16 entries stored places cmd_data on top. In the next cycle tos shows that word and depth has risen by one.
- R2: An accepted pop (code 1) on a non-empty store raises pop_valid for exactly one cycle, in the cycle after acceptance, with pop_data equal to the old top. depth falls by one and tos shows the entry that was beneath.
- R3: Add (code 2) and multiply (code 4) replace the two upper entries with their sum or with the low 16 bits of their product, and depth falls by one. The new values are visible in the next cycle.
- R4: Subtract (code 3) leaves top minus the entry beneath it. So pushing B and then A yields A-B.
- R5: Divide (code 5) leaves the entry beneath the top divided by the top, as signed values truncated toward zero. The result and the reduced depth appear 17 cycles after acceptance, and cmd_ready stays low for exactly those 17 cycles.
- R6: A push with 16 entries stored raises err_overflow for one cycle and leaves tos and depth unchanged.
- R7: A pop on an empty store, or an arithmetic command with fewer than two entries, raises err_underflow for one cycle and leaves tos and depth unchanged.
- R8: A divide with a zero top and at least two entries raises err_divzero for one cycle. Both operands stay in place, no result is pushed, and cmd_ready stays high.
- R9: After reset, depth is 0, tos reads 0, all flags and pop_valid are low, and cmd_ready is high. tos reads 0 whenever the store is empty.
- R10: Codes 6 and 7 are accepted but change nothing and raise no flag.
- R11: The sequence push B, push A, subtract, push E, push D, multiply, push C, add, divide leaves exactly one entry equal to (A-B)/(C+D*E).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block will take a command this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_data | input | 16 | Word for a push |
| pop_valid | output | 1 | One-cycle strobe: pop_data holds a popped word |
| pop_data | output | 16 | The word removed by the last pop |
| tos | output | 16 | Current top entry, 0 when empty |
| depth | output | 5 | Number of stored entries |
| err_overflow | output | 1 | One-cycle flag: push refused, store full |
| err_underflow | output | 1 | One-cycle flag: too few entries for the command |
| err_divzero | output | 1 | One-cycle flag: divide refused, zero divisor |

## Verification
Every command except a divide shows its effect on tos, depth, pop_valid, pop_data and the flags one register stage after the accepting edge. A started divide holds cmd_ready low and shows its quotient 17 edges after acceptance. The bench keeps a behavioural queue model that advances on the same rising edges, with a down-counter standing for the divide delay. It compares every output with the model at each falling edge, so a result that comes one cycle early or late is caught as readily as a wrong value.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;

   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_POP  = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_MUL  = 3'd4,
      OP_DIV  = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      ST_HOLD,
      ST_PUSH,
      ST_POP,
      ST_FOLD
   } st_op_e;

endpackage

// File: rtl/stack_store.sv
module stack_store
   import stack_calc_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  st_op_e        op,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  top,
   output logic [W-1:0]  next,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stack_store: DEPTH must be at least 2");
      end
      if (W < 2) begin : g_bad_width
         $error("stack_store: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         case (op)
            ST_PUSH: begin
               mem[AW'(cnt_q)] <= wdata;
               cnt_q <= cnt_q + CW'(1);
            end
            ST_POP: cnt_q <= cnt_q - CW'(1);
            ST_FOLD: begin
               mem[AW'(cnt_q - CW'(2))] <= wdata;
               cnt_q <= cnt_q - CW'(1);
            end
            default: ;
         endcase
      end
   end

   assign top   = (cnt_q == '0)     ? '0 : mem[AW'(cnt_q - CW'(1))];
   assign next  = (cnt_q < CW'(2))  ? '0 : mem[AW'(cnt_q - CW'(2))];
   assign count = cnt_q;

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL); // R6
   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ST_PUSH) |-> (cnt_q != FULL)); // R6
   AST_FOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ST_FOLD) |-> (cnt_q >= CW'(2))); // R7

endmodule

// File: rtl/stack_alu.sv
module stack_alu
   import stack_calc_pkg::*;
#(
   parameter int W = 16
) (
   input  op_e          op,
   input  logic [W-1:0] top,
   input  logic [W-1:0] next,
   output logic [W-1:0] result
);

   always_comb begin
      case (op)
         OP_ADD:  result = top + next;
         OP_SUB:  result = top - next;
         OP_MUL:  result = top * next;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/stack_divider.sv
module stack_divider #(
   parameter int W  = 16,
   localparam int KW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient
);

   generate
      if (W < 2) begin : g_bad_width
         $error("stack_divider: W must be at least 2");
      end
   endgenerate

   function automatic logic [W-1:0] mag(input logic [W-1:0] v);
      return v[W-1] ? (~v + W'(1)) : v;
   endfunction

   logic           busy_q, done_q, neg_q;
   logic [KW-1:0]  cnt_q;
   logic [2*W-1:0] rq_q, rq_n, shifted;
   logic [W-1:0]   dsr_q, quo_q, hi;

   always_comb begin
      shifted = {rq_q[2*W-2:0], 1'b0};
      hi      = shifted[2*W-1:W];
      if (hi >= dsr_q) rq_n = {hi - dsr_q, shifted[W-1:1], 1'b1};
      else             rq_n = shifted;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         neg_q  <= 1'b0;
         cnt_q  <= '0;
         rq_q   <= '0;
         dsr_q  <= '0;
         quo_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         neg_q  <= dividend[W-1] ^ divisor[W-1];
         cnt_q  <= KW'(W);
         rq_q   <= {{W{1'b0}}, mag(dividend)};
         dsr_q  <= mag(divisor);
      end else if (busy_q) begin
         rq_q  <= rq_n;
         cnt_q <= cnt_q - KW'(1);
         if (cnt_q == KW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            quo_q  <= neg_q ? (~rq_n[W-1:0] + W'(1)) : rq_n[W-1:0];
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign quotient = quo_q;

   AST_DIV_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R5
   AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !start); // R5

endmodule

// File: rtl/stack_calc.sv
module stack_calc
   import stack_calc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic [DATA_W-1:0] tos,
   output logic [CW-1:0]     depth,
   output logic              err_overflow,
   output logic              err_underflow,
   output logic              err_divzero
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [CW-1:0] PAIR = CW'(2);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stack_calc: DEPTH must be at least 2");
      end
   endgenerate

   op_e               op;
   st_op_e            st_op;
   logic [DATA_W-1:0] st_wdata, top_w, next_w, alu_r, div_q;
   logic [CW-1:0]     cnt;
   logic              accept, div_go, div_done, div_busy, div_pend_q;
   logic              ov_n, un_n, dz_n, pv_n;

   assign op        = op_e'(cmd_op);
   assign cmd_ready = !div_pend_q;
   assign accept    = cmd_valid && cmd_ready;

   stack_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (st_op),
      .wdata (st_wdata),
      .top   (top_w),
      .next  (next_w),
      .count (cnt)
   );

   stack_alu #(.W(DATA_W)) u_alu (
      .op     (op),
      .top    (top_w),
      .next   (next_w),
      .result (alu_r)
   );

   stack_divider #(.W(DATA_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_go),
      .dividend (next_w),
      .divisor  (top_w),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (div_q)
   );

   always_comb begin
      st_op    = ST_HOLD;
      st_wdata = cmd_data;
      ov_n     = 1'b0;
      un_n     = 1'b0;
      dz_n     = 1'b0;
      pv_n     = 1'b0;
      div_go   = 1'b0;
      if (div_done) begin
         st_op    = ST_FOLD;
         st_wdata = div_q;
      end else if (accept) begin
         case (op)
            OP_PUSH: begin
               if (cnt == FULL) ov_n = 1'b1;
               else             st_op = ST_PUSH;
            end
            OP_POP: begin
               if (cnt == '0) un_n = 1'b1;
               else begin
                  st_op = ST_POP;
                  pv_n  = 1'b1;
               end
            end
            OP_ADD, OP_SUB, OP_MUL: begin
               if (cnt < PAIR) un_n = 1'b1;
               else begin
                  st_op    = ST_FOLD;
                  st_wdata = alu_r;
               end
            end
            OP_DIV: begin
               if (cnt < PAIR)        un_n   = 1'b1;
               else if (top_w == '0)  dz_n   = 1'b1;
               else                   div_go = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_pend_q    <= 1'b0;
         pop_valid     <= 1'b0;
         pop_data      <= '0;
         err_overflow  <= 1'b0;
         err_underflow <= 1'b0;
         err_divzero   <= 1'b0;
      end else begin
         if (div_go)        div_pend_q <= 1'b1;
         else if (div_done) div_pend_q <= 1'b0;
         pop_valid     <= pv_n;
         if (pv_n) pop_data <= top_w;
         err_overflow  <= ov_n;
         err_underflow <= un_n;
         err_divzero   <= dz_n;
      end
   end

   assign tos   = top_w;
   assign depth = cnt;

   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_PUSH && depth != FULL) |=>
         (tos == $past(cmd_data) && depth == $past(depth) + CW'(1))); // R1
   AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_POP && depth != '0) |=>
         (pop_valid && pop_data == $past(tos))); // R2
   AST_FOLD_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (op == OP_ADD || op == OP_SUB || op == OP_MUL) && depth >= PAIR) |=>
         (depth == $past(depth) - CW'(1))); // R3
   AST_DIV_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_DIV && depth >= PAIR && tos != '0) |=>
         (!cmd_ready && $stable(depth))); // R5
   AST_DIV_BUSY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !cmd_ready); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_PUSH && depth == FULL) |=>
         (err_overflow && $stable(depth) && $stable(tos))); // R6
   AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_POP && depth == '0) |=>
         (err_underflow && depth == '0)); // R7
   AST_DIVZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_DIV && depth >= PAIR && tos == '0) |=>
         (err_divzero && $stable(depth) && cmd_ready)); // R8
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pop_valid, err_overflow, err_underflow, err_divzero})); // R2

endmodule

// File: tb/stack_calc_test.sv
module stack_calc_test;

   localparam int W       = 16;
   localparam int DEPTH   = 16;
   localparam int DIV_LAT = W + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [2:0]   cmd_op = 3'd0;
   logic [W-1:0] cmd_data = '0;
   logic         pop_valid;
   logic [W-1:0] pop_data, tos;
   logic [4:0]   depth;
   logic         err_overflow, err_underflow, err_divzero;

   always #2 clk = ~clk;

   stack_calc uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_op        (cmd_op),
      .cmd_data      (cmd_data),
      .pop_valid     (pop_valid),
      .pop_data      (pop_data),
      .tos           (tos),
      .depth         (depth),
      .err_overflow  (err_overflow),
      .err_underflow (err_underflow),
      .err_divzero   (err_divzero)
   );

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R9";
   bit    comparing = 0;

   // behavioural reference model
   logic [W-1:0] mstk[$];
   int           busy_cnt = 0;
   logic [W-1:0] div_res = '0;
   logic         e_pv = 0, e_ov = 0, e_un = 0, e_dz = 0;
   logic [W-1:0] e_pd = '0;

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mstk.delete();
         busy_cnt = 0;
         e_pv = 0; e_ov = 0; e_un = 0; e_dz = 0; e_pd = '0;
      end else begin
         logic [W-1:0] t, n;
         int ti, ni;
         e_pv = 0; e_ov = 0; e_un = 0; e_dz = 0;
         if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) begin
               void'(mstk.pop_back());
               void'(mstk.pop_back());
               mstk.push_back(div_res);
            end
         end else if (cmd_valid) begin
            case (cmd_op)
               3'd0: if (mstk.size() == DEPTH) e_ov = 1; else mstk.push_back(cmd_data);
               3'd1: if (mstk.size() == 0) e_un = 1;
                     else begin e_pd = mstk.pop_back(); e_pv = 1; end
               3'd2, 3'd3, 3'd4, 3'd5: begin
                  if (mstk.size() < 2) e_un = 1;
                  else begin
                     t = mstk[mstk.size()-1];
                     n = mstk[mstk.size()-2];
                     ti = int'($signed(t));
                     ni = int'($signed(n));
                     if (cmd_op == 3'd5) begin
                        if (ti == 0) e_dz = 1;
                        else begin
                           div_res = 16'(ni / ti);
                           busy_cnt = DIV_LAT;
                        end
                     end else begin
                        void'(mstk.pop_back());
                        void'(mstk.pop_back());
                        if (cmd_op == 3'd2)      mstk.push_back(16'(ti + ni));
                        else if (cmd_op == 3'd3) mstk.push_back(16'(ti - ni));
                        else                     mstk.push_back(16'(ti * ni));
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (comparing) begin
         chk("tos", tos, (mstk.size() > 0) ? mstk[mstk.size()-1] : 16'h0);
         chk("depth", 16'(depth), 16'(mstk.size()));
         chk("cmd_ready", 16'(cmd_ready), 16'(busy_cnt == 0));
         chk("pop_valid", 16'(pop_valid), 16'(e_pv));
         if (e_pv) chk("pop_data", pop_data, e_pd);
         chk("err_overflow", 16'(err_overflow), 16'(e_ov));
         chk("err_underflow", 16'(err_underflow), 16'(e_un));
         chk("err_divzero", 16'(err_divzero), 16'(e_dz));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=<50000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic send(input logic [2:0] op, input logic [W-1:0] data);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_data  = data;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic push(input int v);
      send(3'd0, 16'(v));
   endtask

   task automatic drain();
      while (depth != 0 || !cmd_ready) send(3'd1, '0);
   endtask

   task automatic settle();
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs while reset is held
      chk("reset depth", 16'(depth), 16'h0);
      chk("reset tos", tos, 16'h0);
      chk("reset ready", 16'(cmd_ready), 16'h1);
      rst_n = 1'b1;
      comparing = 1;
      @(negedge clk);

      cur_req = "R1";
      push(11); push(22); push(-5);
      cur_req = "R2";
      send(3'd1, '0); send(3'd1, '0); send(3'd1, '0);
      cur_req = "R7";
      send(3'd1, '0);
      push(4);
      send(3'd2, '0);
      send(3'd5, '0);
      drain();

      cur_req = "R3";
      push(7); push(5); send(3'd2, '0);
      push(300); push(300); send(3'd4, '0);
      push(-3); push(4); send(3'd4, '0);
      push(-32768); push(-1); send(3'd2, '0);
      drain();

      cur_req = "R4";
      push(10); push(3); send(3'd3, '0);
      chk("sub result", tos, 16'hFFF9);
      push(-32768); push(1); send(3'd3, '0);
      drain();

      cur_req = "R5";
      push(100); push(7); send(3'd5, '0);
      settle();
      chk("div 100/7", tos, 16'd14);
      push(-7); push(2); send(3'd5, '0);
      settle();
      push(7); push(-2); send(3'd5, '0);
      settle();
      push(-32768); push(-1); send(3'd5, '0);
      settle();
      push(3); push(9); send(3'd5, '0);
      settle();
      chk("div 3/9", tos, 16'd0);
      drain();

      cur_req = "R8";
      push(5); push(0); send(3'd5, '0);
      @(negedge clk);
      chk("divzero depth kept", 16'(depth), 16'd2);
      drain();

      cur_req = "R10";
      push(33); send(3'd6, 16'd9); send(3'd7, 16'd9);
      chk("reserved tos", tos, 16'd33);
      drain();

      cur_req = "R6";
      for (int i = 0; i < DEPTH; i++) push(i + 100);
      push(999);
      push(998);
      chk("full depth", 16'(depth), 16'(DEPTH));
      drain();

      cur_req = "R11";
      // A=50 B=8 C=1 D=2 E=3 -> 42/7 = 6
      push(8); push(50); send(3'd3, '0);
      push(3); push(2); send(3'd4, '0);
      push(1); send(3'd2, '0);
      send(3'd5, '0);
      settle();
      chk("expression value", tos, 16'd6);
      chk("expression depth", 16'(depth), 16'd1);
      drain();

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule